// File: doc/BRIEF.md
# Extended-Precision Exponent/Significand Splitter

This block splits an 80-bit extended-precision floating-point value into two parts. The value sits at the top of an eight-slot circular register stack that the block owns. The first part is the value's true (unbiased) exponent, written back as a normalized extended-precision number. The second part is the significand, rebased so that its own true exponent is zero. After one operation the new top of stack holds the significand and the entry below it holds the exponent. Multiplying the significand by two raised to the exponent gives back the original finite value exactly.

The stack keeps one occupancy bit per slot. The block updates the top pointer itself. A single `start` pulse launches an operation, and `done` pulses a fixed number of cycles later. When `done` pulses, the zero-divide and stack-overflow flags are valid. They hold their values until the next accepted start.

A load port and a registered read port give access to any physical slot. They are used to place operands in the stack and to observe the results.

Top module: `xfs_splitter`

## Requirements
- R1: Word layout is sign in bit 79, biased exponent in bits 78:64 and explicit significand in bits 63:0. For a finite nonzero operand, the significand result keeps the operand's sign and gets biased exponent 0x3FFF. For a normal operand, its 64 significand bits are unchanged.
- R2: For a finite nonzero operand, the exponent result is the true exponent (biased field minus 16383) written as a normalized extended value with bit 63 set. The sign of the exponent result is the sign of that integer. A true exponent of zero gives +0.0 (all 80 bits zero).
- R3: A denormal operand (exponent field 0, nonzero significand) is first shifted left until bit 63 is set. Its true exponent is -16382 minus the shift count. In every finite nonzero case, significand result times 2^exponent result equals the operand exactly.
- R4: The exponent result overwrites the slot at the current top. The top pointer then decrements modulo the depth, and the significand result goes into the new top slot. Both slots end with occupancy bit 1.
- R5: A zero operand of either sign gives negative infinity (0xFFFF_8000000000000000) as the exponent result. The significand result is a zero carrying the operand's sign, and `zero_div` is 1.
- R6: An infinity operand gives +infinity (0x7FFF_8000000000000000) as the exponent result and the operand itself as the significand result. A NaN operand (exponent field 0x7FFF, bits 62:0 nonzero) is copied unchanged into both results.
- R7: `stk_ovf` goes to 1 if the slot that becomes the new top already has occupancy bit 1 before the push. That slot then receives the default quiet NaN 0xFFFF_C000000000000000 instead of the significand. The exponent result is still written.
- R8: `done` rises exactly four clock edges after the edge that accepts `start` and is a one-cycle pulse. `zero_div` and `stk_ovf` change only when `done` rises or at an accepted start, where they are cleared.
- R9: A `start` arriving while an operation is in flight is ignored. It produces no extra `done` and no extra pointer decrement.
- R10: After reset the top pointer is 0, every occupancy bit is 0, and `done`, `zero_div` and `stk_ovf` are 0.
- R11: While idle, `ld_en` writes `ld_data` into slot `ld_idx` and sets that slot's occupancy bit to `ld_tag`. `rd_data` and `rd_tag` show slot `rd_idx` one clock after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch one split on the current top slot |
| done | output | 1 | One-cycle completion pulse |
| zero_div | output | 1 | Zero operand seen in the last operation |
| stk_ovf | output | 1 | Push landed on an occupied slot in the last operation |
| top_ptr | output | 3 | Physical index of the current top slot |
| ld_en | input | 1 | Load strobe, honoured only while idle |
| ld_idx | input | 3 | Physical slot to load |
| ld_data | input | 80 | Word to load |
| ld_tag | input | 1 | Occupancy bit to store with the load |
| rd_idx | input | 3 | Physical slot to observe |
| rd_data | output | 80 | Registered word of slot `rd_idx` |
| rd_tag | output | 1 | Registered occupancy bit of slot `rd_idx` |

## Verification
The bench sweeps the biased exponent across its whole normal range, including the field value 16383, and every denormal shift count from 0 to 63. A converter with a priority-encoder or bias error would return the wrong exponent word, and a faulty denormal shift would break exact reconstruction. The bench also runs signed zeros, infinities, quiet and signalling NaNs, and a push onto an occupied slot. A design that mishandles these would miss the negative-infinity or quiet-NaN substitution, or raise the wrong flag. Pointer wrap from slot 0 to slot 7 and a start issued while busy check that exactly one decrement happens per operation.

// File: rtl/xfs_pkg.sv
package xfs_pkg;
  localparam int EXP_W  = 15;
  localparam int MAN_W  = 64;
  localparam int WORD_W = 1 + EXP_W + MAN_W;

  typedef struct packed {
    logic             sgn;
    logic [EXP_W-1:0] bexp;
    logic [MAN_W-1:0] man;
  } ext_t;

  localparam logic [EXP_W-1:0] BIAS_EXP = 15'h3FFF;
  localparam logic [EXP_W-1:0] MAX_EXP  = 15'h7FFF;

  localparam ext_t POS_INF  = '{sgn: 1'b0, bexp: MAX_EXP, man: 64'h8000_0000_0000_0000};
  localparam ext_t NEG_INF  = '{sgn: 1'b1, bexp: MAX_EXP, man: 64'h8000_0000_0000_0000};
  localparam ext_t QNAN_DEF = '{sgn: 1'b1, bexp: MAX_EXP, man: 64'hC000_0000_0000_0000};

  typedef enum logic [1:0] {ST_IDLE, ST_CONV, ST_WEXP, ST_WSIG} seq_t;
endpackage

// File: rtl/xfs_lzc.sv
module xfs_lzc #(
  parameter int W = 64
) (
  input  logic [W-1:0]         vec,
  output logic [$clog2(W)-1:0] cnt,
  output logic                 none
);
  localparam int CW = $clog2(W);

  // Scan from the top bit; the first one found fixes the count.
  always_comb begin
    cnt  = '0;
    none = 1'b1;
    for (int i = 0; i < W; i++) begin
      if (none && vec[W-1-i]) begin
        cnt  = CW'(i);
        none = 1'b0;
      end
    end
  end
endmodule

// File: rtl/xfs_int2ext.sv
module xfs_int2ext
  import xfs_pkg::*;
(
  input  logic signed [16:0] val,
  output ext_t               res
);
  logic [14:0] mag;
  logic [3:0]  lz;
  logic        none;
  logic [63:0] shifted;

  assign mag = val[16] ? 15'(-val) : val[14:0];

  xfs_lzc #(.W(15)) u_lz (.vec(mag), .cnt(lz), .none(none));

  // Leading one at position 14-lz moves to bit 63: shift by 49+lz.
  assign shifted = {49'd0, mag} << (6'd49 + {2'b00, lz});

  always_comb begin
    if (none) res = '0;
    else      res = '{sgn: val[16], bexp: 15'(16'd16397 - {12'd0, lz}), man: shifted};
  end

  // R2: a nonzero integer always converts to a normalized word
  always_comb begin
    if (!none) assert_int_norm_R2: assert (res.man[63] && res.bexp >= BIAS_EXP);
  end
endmodule

// File: rtl/xfs_core.sv
module xfs_core
  import xfs_pkg::*;
(
  input  ext_t opnd,
  output ext_t exp_res,
  output ext_t sig_res,
  output logic zdiv
);
  logic              all_ones, exp_zero, man_zero, frac_zero;
  logic [5:0]        mlz;
  logic signed [16:0] unb;
  logic [63:0]       nman;
  ext_t              cvt;

  assign all_ones  = &opnd.bexp;
  assign exp_zero  = ~|opnd.bexp;
  assign frac_zero = ~|opnd.man[62:0];

  xfs_lzc #(.W(MAN_W)) u_mlz (.vec(opnd.man), .cnt(mlz), .none(man_zero));

  // Denormals are normalized; their true exponent drops by the shift.
  always_comb begin
    if (exp_zero) begin
      unb  = -17'sd16382 - $signed({11'd0, mlz});
      nman = opnd.man << mlz;
    end else begin
      unb  = $signed({2'b00, opnd.bexp}) - 17'sd16383;
      nman = opnd.man;
    end
  end

  xfs_int2ext u_cvt (.val(unb), .res(cvt));

  always_comb begin
    zdiv    = 1'b0;
    exp_res = cvt;
    sig_res = '{sgn: opnd.sgn, bexp: BIAS_EXP, man: nman};
    if (all_ones) begin
      sig_res = opnd;
      exp_res = frac_zero ? POS_INF : opnd;
    end else if (exp_zero && man_zero) begin
      zdiv    = 1'b1;
      exp_res = NEG_INF;
      sig_res = '{sgn: opnd.sgn, bexp: '0, man: '0};
    end
  end
endmodule

// File: rtl/xfs_splitter.sv
module xfs_splitter
  import xfs_pkg::*;
#(
  parameter  int STACK_DEPTH = 8,
  localparam int PTR_W       = $clog2(STACK_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              done,
  output logic              zero_div,
  output logic              stk_ovf,
  output logic [PTR_W-1:0]  top_ptr,
  input  logic              ld_en,
  input  logic [PTR_W-1:0]  ld_idx,
  input  logic [WORD_W-1:0] ld_data,
  input  logic              ld_tag,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_tag
);
  seq_t                   state_q;
  logic [PTR_W-1:0]       top_q, wr_addr;
  logic [STACK_DEPTH-1:0] tag_q;
  logic [WORD_W-1:0]      stk_mem [STACK_DEPTH];
  logic [WORD_W-1:0]      opnd_raw, wr_data;
  ext_t                   opnd_x, exp_c, sig_c, exp_q, sig_q;
  logic                   zd_c, zd_q, ovf_q, accept, wr_en;

  assign accept  = start && (state_q == ST_IDLE);
  assign opnd_x  = opnd_raw;
  assign top_ptr = top_q;

  xfs_core u_core (.opnd(opnd_x), .exp_res(exp_c), .sig_res(sig_c), .zdiv(zd_c));

  // Single write port shared by the two result writes and the load path.
  always_comb begin
    wr_en   = 1'b0;
    wr_addr = ld_idx;
    wr_data = ld_data;
    case (state_q)
      ST_IDLE: wr_en = ld_en;
      ST_WEXP: begin wr_en = 1'b1; wr_addr = top_q; wr_data = exp_q; end
      ST_WSIG: begin wr_en = 1'b1; wr_addr = top_q; wr_data = ovf_q ? QNAN_DEF : sig_q; end
      default: wr_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (wr_en) stk_mem[wr_addr] <= wr_data;
    if (accept) opnd_raw <= stk_mem[top_q];
    rd_data <= stk_mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      top_q    <= '0;
      tag_q    <= '0;
      done     <= 1'b0;
      zero_div <= 1'b0;
      stk_ovf  <= 1'b0;
      zd_q     <= 1'b0;
      ovf_q    <= 1'b0;
      rd_tag   <= 1'b0;
      exp_q    <= '0;
      sig_q    <= '0;
    end else begin
      done   <= 1'b0;
      rd_tag <= tag_q[rd_idx];
      case (state_q)
        ST_IDLE: begin
          if (ld_en) tag_q[ld_idx] <= ld_tag;
          if (accept) begin
            state_q  <= ST_CONV;
            zero_div <= 1'b0;
            stk_ovf  <= 1'b0;
          end
        end
        ST_CONV: begin
          exp_q   <= exp_c;
          sig_q   <= sig_c;
          zd_q    <= zd_c;
          state_q <= ST_WEXP;
        end
        ST_WEXP: begin
          tag_q[top_q] <= 1'b1;
          ovf_q        <= tag_q[top_q - 1'b1];
          top_q        <= top_q - 1'b1;
          state_q      <= ST_WSIG;
        end
        default: begin
          tag_q[top_q] <= 1'b1;
          done         <= 1'b1;
          zero_div     <= zd_q;
          stk_ovf      <= ovf_q;
          state_q      <= ST_IDLE;
        end
      endcase
    end
  end

  assert_done_latency_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(accept, 4));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_flag_timing_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(stk_ovf) |-> done);
  assert_one_step_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> (top_q + 1'b1) == $past(top_q, 4));
  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE && start) |=> state_q != ST_CONV);
  assert_zero_neginf_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WEXP && zd_q) |-> exp_q == NEG_INF);
  assert_sig_bias_R1: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WEXP && !zd_q && sig_q.bexp != MAX_EXP) |-> sig_q.bexp == BIAS_EXP);
endmodule

// File: tb/xfs_splitter_bench.sv
`timescale 1ns/1ps
module xfs_splitter_bench;
  localparam logic [79:0] NINF = 80'hFFFF_8000_0000_0000_0000;
  localparam logic [79:0] PINF = 80'h7FFF_8000_0000_0000_0000;
  localparam logic [79:0] QNAN = 80'hFFFF_C000_0000_0000_0000;

  logic        clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic        done, zero_div, stk_ovf, rd_tag;
  logic [2:0]  top_ptr, ld_idx = '0, rd_idx = '0;
  logic        ld_en = 1'b0, ld_tag = 1'b0;
  logic [79:0] ld_data = '0, rd_data;
  logic [2:0]  exp_top;
  int          n_vec = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  xfs_splitter u_xfs_splitter (
    .clk(clk), .rst(rst), .start(start), .done(done), .zero_div(zero_div),
    .stk_ovf(stk_ovf), .top_ptr(top_ptr), .ld_en(ld_en), .ld_idx(ld_idx),
    .ld_data(ld_data), .ld_tag(ld_tag), .rd_idx(rd_idx), .rd_data(rd_data), .rd_tag(rd_tag));

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exv);
    end
  endtask

  function automatic logic [79:0] b_int2ext(input int u);
    logic [63:0] mt;
    int be, a;
    if (u == 0) return '0;
    a  = (u < 0) ? -u : u;
    mt = 64'(a);
    be = 16383 + 63;
    while (!mt[63]) begin mt = mt << 1; be--; end
    return {u < 0, 15'(be), mt};
  endfunction

  function automatic int b_ext2int(input logic [79:0] ex);
    int sh;
    logic [63:0] mg;
    if (ex[78:0] == '0) return 0;
    sh = 16383 + 63 - int'(ex[78:64]);
    mg = ex[63:0] >> sh;
    return ex[79] ? -int'(mg) : int'(mg);
  endfunction

  function automatic void b_model(input logic [79:0] op, output logic [79:0] ex,
                                  output logic [79:0] sg, output logic zd);
    logic [63:0] mm;
    int u;
    zd = 1'b0;
    mm = op[63:0];
    if (op[78:64] == 15'h7FFF) begin
      sg = op;
      ex = (op[62:0] == '0) ? PINF : op;
    end else if (op[78:0] == '0) begin
      zd = 1'b1;
      ex = NINF;
      sg = {op[79], 79'd0};
    end else begin
      if (op[78:64] == '0) begin
        u = -16382;
        while (!mm[63]) begin mm = mm << 1; u--; end
      end else u = int'(op[78:64]) - 16383;
      sg = {op[79], 15'h3FFF, mm};
      ex = b_int2ext(u);
    end
  endfunction

  task automatic do_load(input logic [2:0] idx, input logic [79:0] d, input logic tg);
    ld_en = 1'b1; ld_idx = idx; ld_data = d; ld_tag = tg;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic rd_slot(input logic [2:0] idx, output logic [79:0] d, output logic tg);
    rd_idx = idx;
    @(negedge clk);
    d = rd_data; tg = rd_tag;
  endtask

  task automatic test_op(input logic [79:0] op, input bit full_nb, input string rq);
    logic [79:0] ex_e, sg_e, a_sig, a_exp;
    logic zd_e, t_sig, t_exp;
    logic [2:0] nt;
    int lat, u, e0, k;
    bit ok;
    b_model(op, ex_e, sg_e, zd_e);
    if (full_nb) sg_e = QNAN;
    nt = exp_top - 3'd1;
    do_load(exp_top, op, 1'b1);
    do_load(nt, 80'h1234_5678, full_nb);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 12) begin @(negedge clk); lat++; end
    chk(lat == 4, "R8 done latency", 80'(lat), 80'd4);
    chk(zero_div == zd_e, "R5 zero_div flag", 80'(zero_div), 80'(zd_e));
    chk(stk_ovf == full_nb, "R7 stk_ovf flag", 80'(stk_ovf), 80'(full_nb));
    @(negedge clk);
    chk(!done, "R8 done pulse width", 80'(done), 80'd0);
    exp_top = nt;
    chk(top_ptr == exp_top, "R4 top pointer", 80'(top_ptr), 80'(exp_top));
    rd_slot(nt, a_sig, t_sig);
    rd_slot(3'(nt + 3'd1), a_exp, t_exp);
    chk(a_sig == sg_e, full_nb ? "R7 qnan in new top" : "R1 significand in ST0", a_sig, sg_e);
    chk(a_exp == ex_e, rq, a_exp, ex_e);
    chk(t_sig && t_exp, "R4 occupancy bits", 80'({t_sig, t_exp}), 80'd3);
    if (!full_nb && op[78:64] != 15'h7FFF && op[78:0] != '0) begin
      u  = b_ext2int(a_exp);
      e0 = (op[78:64] == '0) ? -16382 : int'(op[78:64]) - 16383;
      k  = e0 - u;
      ok = (k >= 0) && (k < 64) && a_sig[79] == op[79] && a_sig[78:64] == 15'h3FFF
           && ((a_sig[63:0] >> k) == op[63:0]) && (((a_sig[63:0] >> k) << k) == a_sig[63:0]);
      chk(ok, "R2 R3 exact reconstruction", a_sig, op);
    end
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [79:0] d, ex_m, sg_m;
    logic tg, zd_m;
    int dn;
    exp_top = 3'd0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(top_ptr == 3'd0, "R10 reset top", 80'(top_ptr), 80'd0);
    chk({done, zero_div, stk_ovf} == 3'b000, "R10 reset outputs", 80'({done, zero_div, stk_ovf}), 80'd0);
    for (int i = 0; i < 8; i++) begin
      rd_slot(3'(i), d, tg);
      chk(!tg, "R10 reset occupancy", 80'(tg), 80'd0);
    end

    do_load(3'd5, 80'hABCD_0123_4567_89AB_CDEF, 1'b1);
    rd_slot(3'd5, d, tg);
    chk(d == 80'hABCD_0123_4567_89AB_CDEF && tg, "R11 load and read", d, 80'hABCD_0123_4567_89AB_CDEF);
    do_load(3'd5, 80'd0, 1'b0);
    rd_slot(3'd5, d, tg);
    chk(!tg, "R11 occupancy cleared by load", 80'(tg), 80'd0);

    b_model(80'h3FFF_8000_0000_0000_0000, ex_m, sg_m, zd_m);
    chk(ex_m == 80'd0, "R2 exponent zero gives +0", ex_m, 80'd0);
    b_model(80'h3FFD_8000_0000_0000_0000, ex_m, sg_m, zd_m);
    chk(ex_m == 80'hC000_8000_0000_0000_0000, "R2 minus two", ex_m, 80'hC000_8000_0000_0000_0000);
    b_model(80'h0000_0000_0000_0000_0001, ex_m, sg_m, zd_m);
    chk(ex_m == 80'hC00D_807A_0000_0000_0000, "R3 smallest denormal", ex_m, 80'hC00D_807A_0000_0000_0000);

    // wraps 0 -> 7 on the first push
    test_op(80'h3FFF_8000_0000_0000_0000, 1'b0, "R2 exponent of one");
    test_op(80'h4000_8000_0000_0000_0000, 1'b0, "R2 exponent of two");
    test_op(80'h7FFE_FFFF_FFFF_FFFF_FFFF, 1'b0, "R2 largest exponent");
    for (int e = 1; e <= 32766; e += 61)
      test_op({1'(e & 1), 15'(e), 1'b1, 63'(e * 40503)}, 1'b0, "R2 exponent sweep");
    for (int k = 0; k < 64; k++)
      test_op({1'(k & 1), 15'd0, 64'hFFFF_FFFF_FFFF_FFFF >> k}, 1'b0, "R3 denormal sweep");
    test_op(80'h0000_0000_0000_0000_0000, 1'b0, "R5 positive zero");
    test_op(80'h8000_0000_0000_0000_0000, 1'b0, "R5 negative zero");
    test_op(PINF, 1'b0, "R6 positive infinity");
    test_op(NINF, 1'b0, "R6 negative infinity");
    test_op(80'h7FFF_C000_0000_0000_1234, 1'b0, "R6 quiet NaN");
    test_op(80'hFFFF_8000_0000_0000_0001, 1'b0, "R6 signalling NaN");
    test_op(80'h4005_A000_0000_0000_0000, 1'b1, "R7 exponent still written");
    test_op(80'h0000_0000_0000_0000_0000, 1'b1, "R7 overflow on zero");

    // R9: second start while busy
    do_load(exp_top, 80'h4001_C000_0000_0000_0000, 1'b1);
    do_load(3'(exp_top - 3'd1), 80'd0, 1'b0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dn = 0;
    for (int c = 0; c < 12; c++) begin
      start = (c == 1);
      @(negedge clk);
      if (done) dn++;
    end
    start = 1'b0;
    exp_top = exp_top - 3'd1;
    chk(dn == 1, "R9 single done", 80'(dn), 80'd1);
    chk(top_ptr == exp_top, "R9 single decrement", 80'(top_ptr), 80'(exp_top));

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule